// File: doc/BRIEF.md
# Column-Associative Direct-Mapped Cache

This block is a single-word-per-line cache controller that behaves like a direct-mapped cache, with one addition. When the home line of an address misses, the controller gives the block a second chance in one fixed partner line. The partner line's index is the home index with its most significant bit inverted. Blocks that collide on the same home line can therefore both stay resident, and a hit in the home line keeps plain direct-mapped speed.

A client sends requests on a valid/ready port: a word address, a write flag and write data. It receives a one-cycle response pulse carrying the read data, or the written word for a write. At most one request is in flight. The controller stalls the client while it makes the second probe or waits for the backing memory. The backing memory has a request port and returns read data some fixed number of cycles later with a valid pulse. Writes go through to memory in the cycle they are accepted. When a block hits in its partner line, the two lines swap, so the block that was just used sits in its home slot. When both lines miss, the home line's old occupant moves to the partner slot and the new block takes the home slot.

Top module: `colassoc_cache`

## Requirements
- R1: After reset every line is invalid, `req_ready` is 1, `rsp_valid` is 0 and `mem_req` is 0, so the first access to any address is a miss.
- R2: A request that hits its home line (index = `req_addr[IDX_W-1:0]`, tag = upper address bits) gets `rsp_valid` in the first cycle after acceptance, with the stored word for a read.
- R3: On a home miss the controller probes the partner line whose index has its top bit inverted. A hit there responds in the second cycle after acceptance and reads no memory.
- R4: A partner hit swaps the two lines. The next access to that block hits its home line in one cycle, and the block that was displaced now hits as a partner in two cycles.
- R5: A read that misses both lines issues exactly one memory read and returns the memory word. The block then fills its home line. A valid previous occupant of the home line moves to the partner line, and the partner line's earlier block is dropped.
- R6: Every accepted write raises `mem_req` with `mem_we`=1, `mem_addr`=`req_addr` and `mem_wdata`=`req_wdata` in its acceptance cycle. A write that misses both lines allocates the word without a memory read and responds in the second cycle.
- R7: `req_ready` is 0 from the cycle after a non-home-hit acceptance until the response. `mem_req` with `mem_we`=0 lasts exactly one cycle per miss.
- R8: Each line records whether it holds its own home block or a relocated one. A relocated block whose tag equals the tag of an address homed at that line never hits for that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write word |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | DATA_W | Read word, or the written word for a write |
| mem_req | output | 1 | Backing memory request |
| mem_we | output | 1 | Backing memory write flag |
| mem_addr | output | ADDR_W | Backing memory address |
| mem_wdata | output | DATA_W | Backing memory write word |
| mem_rvalid | input | 1 | Backing memory read data valid |
| mem_rdata | input | DATA_W | Backing memory read word |

## Verification
Directed sequences place two blocks in the same home line and revisit them, so that a partner hit, the swap and the promoted home hit can each be told apart by response latency and by memory read count. A pair of addresses with equal tags and partnered home indexes shows whether the relocation marker prevents a false home hit, which would return the wrong word. A long seeded random mix of reads and writes over few tags keeps both slots of each pair busy. Every read is compared with a reference memory, and the latency class of every access is compared with a model of home, partner and miss outcomes.

// File: rtl/colassoc_cache.sv
module colassoc_cache #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int LINES = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam logic [IDX_W-1:0] FLIP = {1'b1, {(IDX_W-1){1'b0}}};

  typedef enum logic [1:0] {S_IDLE, S_PROBE, S_FETCH, S_WAIT} st_t;
  st_t state;

  logic              v_q   [LINES];
  logic              rel_q [LINES];
  logic [TAG_W-1:0]  tag_q [LINES];
  logic [DATA_W-1:0] dat_q [LINES];

  logic              lat_we;
  logic [IDX_W-1:0]  lat_idx;
  logic [TAG_W-1:0]  lat_tag;
  logic [DATA_W-1:0] lat_wdata;

  logic              accept, prim_hit, alt_hit, fill;
  logic [IDX_W-1:0]  cur_idx, alt_idx;
  logic [TAG_W-1:0]  cur_tag;
  logic [DATA_W-1:0] fill_data;

  assign req_ready = (state == S_IDLE);
  assign accept    = req_valid && req_ready;
  assign cur_idx   = req_ready ? req_addr[IDX_W-1:0] : lat_idx;
  assign cur_tag   = req_ready ? req_addr[ADDR_W-1:IDX_W] : lat_tag;
  assign alt_idx   = cur_idx ^ FLIP;
  assign prim_hit  = v_q[cur_idx] && !rel_q[cur_idx] && (tag_q[cur_idx] == cur_tag);
  assign alt_hit   = v_q[alt_idx] && rel_q[alt_idx] && (tag_q[alt_idx] == cur_tag);

  assign fill      = (state == S_PROBE && !alt_hit && lat_we) || (state == S_WAIT && mem_rvalid);
  assign fill_data = (state == S_WAIT) ? mem_rdata : lat_wdata;

  assign mem_req   = (accept && req_we) || (state == S_FETCH);
  assign mem_we    = req_ready;
  assign mem_addr  = req_ready ? req_addr : {lat_tag, lat_idx};
  assign mem_wdata = req_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      lat_we    <= 1'b0;
      lat_idx   <= '0;
      lat_tag   <= '0;
      lat_wdata <= '0;
      for (int i = 0; i < LINES; i++) begin
        v_q[i]   <= 1'b0;
        rel_q[i] <= 1'b0;
        tag_q[i] <= '0;
        dat_q[i] <= '0;
      end
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          lat_we    <= req_we;
          lat_idx   <= cur_idx;
          lat_tag   <= cur_tag;
          lat_wdata <= req_wdata;
          if (prim_hit) begin
            rsp_valid <= 1'b1;
            rsp_rdata <= req_we ? req_wdata : dat_q[cur_idx];
            if (req_we) dat_q[cur_idx] <= req_wdata;
          end else begin
            state <= S_PROBE;
          end
        end
        S_PROBE: begin
          if (alt_hit) begin
            v_q[lat_idx]   <= 1'b1;
            rel_q[lat_idx] <= 1'b0;
            tag_q[lat_idx] <= lat_tag;
            dat_q[lat_idx] <= lat_we ? lat_wdata : dat_q[alt_idx];
            v_q[alt_idx]   <= v_q[lat_idx];
            rel_q[alt_idx] <= !rel_q[lat_idx];
            tag_q[alt_idx] <= tag_q[lat_idx];
            dat_q[alt_idx] <= dat_q[lat_idx];
            rsp_valid      <= 1'b1;
            rsp_rdata      <= lat_we ? lat_wdata : dat_q[alt_idx];
            state          <= S_IDLE;
          end else if (lat_we) begin
            state <= S_IDLE;
          end else begin
            state <= S_FETCH;
          end
        end
        S_FETCH: state <= S_WAIT;
        S_WAIT:  if (mem_rvalid) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
      if (fill) begin
        if (v_q[lat_idx]) begin
          v_q[alt_idx]   <= 1'b1;
          rel_q[alt_idx] <= !rel_q[lat_idx];
          tag_q[alt_idx] <= tag_q[lat_idx];
          dat_q[alt_idx] <= dat_q[lat_idx];
        end
        v_q[lat_idx]   <= 1'b1;
        rel_q[lat_idx] <= 1'b0;
        tag_q[lat_idx] <= lat_tag;
        dat_q[lat_idx] <= fill_data;
        rsp_valid      <= 1'b1;
        rsp_rdata      <= fill_data;
      end
    end
  end

  p_home_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept && prim_hit |=> rsp_valid);
  p_second_probe_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !prim_hit |=> !rsp_valid && !req_ready);
  p_swap_home_r4: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_PROBE && alt_hit |=> v_q[lat_idx] && !rel_q[lat_idx] && tag_q[lat_idx] == lat_tag);
  p_fetch_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_FETCH |=> !mem_req);
  p_fill_return_r5: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_WAIT && mem_rvalid |=> rsp_valid && rsp_rdata == $past(mem_rdata));
endmodule

// File: tb/colassoc_cache_tb.sv
module colassoc_cache_tb_top;
  localparam int ADDR_W = 8, DATA_W = 16, IDX_W = 3, LAT = 3;
  localparam int LINES = 1 << IDX_W, FLIP = 1 << (IDX_W - 1);

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_we = 0, req_ready, rsp_valid;
  logic [ADDR_W-1:0] req_addr = '0, mem_addr;
  logic [DATA_W-1:0] req_wdata = '0, rsp_rdata, mem_wdata;
  logic mem_req, mem_we, mem_rvalid = 0;
  logic [DATA_W-1:0] mem_rdata = '0;

  always #5 clk = ~clk;

  colassoc_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata));

  logic [DATA_W-1:0] bmem [1<<ADDR_W];
  logic [DATA_W-1:0] refm [1<<ADDR_W];
  int cnt = 0, rdcnt = 0;
  logic [ADDR_W-1:0] raddr = '0;

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (cnt != 0) begin
      cnt <= cnt - 1;
      if (cnt == 1) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= bmem[raddr];
      end
    end
    if (rst_n && mem_req) begin
      if (mem_we) bmem[mem_addr] <= mem_wdata;
      else begin
        cnt   <= LAT;
        raddr <= mem_addr;
        rdcnt <= rdcnt + 1;
      end
    end
  end

  int total = 0, fails = 0, cycles = 0;
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      total = total + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // model of line contents: valid, relocated, home address of held block, data
  bit m_v [LINES];
  bit m_r [LINES];
  logic [ADDR_W-1:0] m_a [LINES];
  logic [DATA_W-1:0] m_d [LINES];

  function automatic int classify(input logic [ADDR_W-1:0] a);
    int h = a % LINES;
    int p = h ^ FLIP;
    if (m_v[h] && !m_r[h] && m_a[h] == a) return 0;
    if (m_v[p] && m_r[p] && m_a[p] == a) return 1;
    return 2;
  endfunction

  task automatic model_update(input int cls, input bit we, input logic [ADDR_W-1:0] a,
                              input logic [DATA_W-1:0] d);
    int h = a % LINES;
    int p = h ^ FLIP;
    if (cls == 1) begin
      bit tv = m_v[h]; bit tr = m_r[h];
      logic [ADDR_W-1:0] ta = m_a[h]; logic [DATA_W-1:0] td = m_d[h];
      m_d[h] = m_d[p];
      m_v[p] = tv; m_r[p] = !tr; m_a[p] = ta; m_d[p] = td;
    end else if (cls == 2 && m_v[h]) begin
      m_v[p] = 1; m_r[p] = !m_r[h]; m_a[p] = m_a[h]; m_d[p] = m_d[h];
    end
    m_v[h] = 1; m_r[h] = 0; m_a[h] = a;
    if (cls == 2 || we) m_d[h] = we ? d : refm[a];
  endtask

  task automatic access(input bit we, input logic [ADDR_W-1:0] a,
                        input logic [DATA_W-1:0] d, output int cls, output int lat);
    int rd0;
    cls = classify(a);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_we = we; req_addr = a; req_wdata = d;
    rd0 = rdcnt;
    #1;
    if (we) chk(mem_req && mem_we && mem_addr == a && mem_wdata == d, "R6 write-through",
                {mem_req, mem_we, mem_addr}, {2'b11, a});
    @(negedge clk);
    req_valid = 0;
    lat = 1;
    if (cls != 0) chk(!req_ready, "R7 ready low while busy", req_ready, 0);
    while (!rsp_valid && lat < 60) begin
      @(negedge clk);
      lat++;
    end
    if (we) refm[a] = d;
    case (cls)
      0: chk(lat == 1, "R2 home-hit latency", lat, 1);
      1: chk(lat == 2, "R3 partner-hit latency", lat, 2);
      default: if (we) chk(lat == 2, "R6 write-miss latency", lat, 2);
               else chk(lat > 2 && lat < 60, "R5 miss latency", lat, LAT + 3);
    endcase
    chk((rdcnt - rd0) == ((cls == 2 && !we) ? 1 : 0), "R5 memory read count",
        rdcnt - rd0, (cls == 2 && !we) ? 1 : 0);
    if (!we) chk(rsp_rdata == refm[a], "R2 R4 R5 read data", rsp_rdata, refm[a]);
    model_update(cls, we, a, d);
  endtask

  initial begin
    int c, l;
    logic [ADDR_W-1:0] x, y, z;
    void'($urandom(32'd1234));
    for (int i = 0; i < (1 << ADDR_W); i++) begin
      bmem[i] = DATA_W'(i * 40503) ^ 16'h5A5A;
      refm[i] = bmem[i];
    end
    for (int i = 0; i < LINES; i++) begin m_v[i] = 0; m_r[i] = 0; m_a[i] = '0; m_d[i] = '0; end
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready && !rsp_valid && !mem_req, "R1 reset outputs",
        {req_ready, rsp_valid, mem_req}, 3'b100);
    access(0, 8'h11, 0, c, l);
    chk(c == 2 && l > 2, "R1 first access misses", l, LAT + 3);

    // R3/R4: two blocks share home line 1
    x = {3'd0, 2'd2, 3'd1};
    y = {3'd0, 2'd3, 3'd1};
    access(0, x, 0, c, l);
    access(0, y, 0, c, l);
    access(0, x, 0, c, l);
    chk(c == 1 && l == 2, "R3 partner hit on x", l, 2);
    access(0, x, 0, c, l);
    chk(c == 0 && l == 1, "R4 swapped block now home", l, 1);
    access(0, y, 0, c, l);
    chk(c == 1 && l == 2, "R4 displaced block partner hit", l, 2);
    access(1, x, 16'hBEEF, c, l);
    chk(c == 1, "R4 write partner hit", c, 1);
    access(0, x, 0, c, l);
    chk(rsp_rdata == 16'hBEEF && l == 1, "R6 written word kept", rsp_rdata, 16'hBEEF);

    // R5: third block drops the partner's block
    z = {3'd0, 2'd1, 3'd1};
    access(0, z, 0, c, l);
    access(0, y, 0, c, l);
    chk(c == 2 && l > 2, "R5 dropped block misses", l, LAT + 3);

    // R8: equal tags across partnered home lines
    x = {3'd0, 2'd1, 3'd2};
    y = {3'd0, 2'd1, 3'd6};
    z = {3'd0, 2'd2, 3'd2};
    access(0, x, 0, c, l);
    access(0, y, 0, c, l);
    access(0, z, 0, c, l);
    access(0, y, 0, c, l);
    chk(c == 2 && rsp_rdata == refm[y], "R8 relocated block no false hit", rsp_rdata, refm[y]);

    // R6 write miss allocates
    access(1, 8'h27, 16'h1234, c, l);
    chk(c == 2 && l == 2, "R6 write miss allocate", l, 2);
    access(0, 8'h27, 0, c, l);
    chk(c == 0 && rsp_rdata == 16'h1234, "R6 allocated read", rsp_rdata, 16'h1234);

    for (int n = 0; n < 400; n++) begin
      logic [ADDR_W-1:0] ra;
      ra = {3'd0, 2'($urandom_range(0, 3)), 3'($urandom_range(0, 7))};
      access($urandom_range(0, 3) == 0, ra, 16'($urandom), c, l);
    end
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule